// File: doc/BRIEF.md
# Segment lookaside buffer

The block is a small, fully associative table that turns the segment part of a 64-bit effective address into a virtual segment descriptor. Each slot holds two 64-bit words. The ESID word carries the effective segment number and a valid bit. The VSID word carries the descriptor, and its top two bits give the segment size of that slot: 256 MB or 1 TB. A lookup port compares the address against every slot at the same time. Within the same cycle it returns a hit flag, the winning slot number and that slot's VSID word.

A command port with a valid/ready handshake carries five operations: store an entry by slot with validation, read back the ESID word or the VSID word of a slot, invalidate every slot except slot 0, and invalidate the slot that an address hits. A response (valid, error, data) appears one cycle after each accepted command. When an invalidate actually clears at least one valid bit, the block tells the downstream translation cache to flush itself.

The control is a two-state machine. `ST_IDLE` accepts commands and holds `cmd_ready_o` high. The transition *drop* (an accepted invalidate that cleared a valid bit) moves it to `ST_FLUSH`. That state lasts exactly one cycle, drives `tlb_flush_o` high and holds `cmd_ready_o` low. The transition *resume* then always returns it to `ST_IDLE`.

Top module: `slb_top`

## Requirements
- R1: An ESID word has its segment number in bits [63:28] and its valid bit in bit 27. VSID bits [63:62] select the size: 00 means 256 MB and 01 means 1 TB. A lookup hits a slot whose ESID word equals {addr[63:28], 1, 27'b0} and whose size is 256 MB. It also hits a slot whose ESID word equals {addr[63:40], 12'b0, 1, 27'b0} and whose size is 1 TB. The hit flag, the slot number and the VSID word of that slot are valid in the same cycle. On a miss the slot number and the VSID output are zero.
- R2: When several slots hit, the lowest-numbered slot is reported.
- R3: A write (opcode 0) takes its slot from bits [11:0] of the RB operand. The write is rejected with an error and stores nothing when any bit of that field at or above bit log2(NUM_SLOTS) is set.
- R4: A write is rejected with an error and stores nothing when RS bit 63 is set. It is also rejected when RS[63:62] is 01 and `cap_1t_i` is low.
- R5: An accepted write responds without error. It stores RB AND 0xFFFF_FFFF_F800_0000 as the ESID word of the slot, so the slot field is removed. It stores RS unchanged as the VSID word.
- R6: Opcode 1 reads the ESID word and opcode 2 reads the VSID word of slot RB[11:0]. A slot at or above NUM_SLOTS returns an error with zero data.
- R7: Invalidate-all (opcode 3) clears bit 27 of every slot from 1 to NUM_SLOTS-1 and leaves slot 0 unchanged.
- R8: Invalidate-by-address (opcode 4) looks up RB under the rule in R1. It clears bit 27 of the reported slot. On a miss no entry changes.
- R9: `tlb_flush_o` is high for exactly one cycle, the cycle after an accepted invalidate that turned at least one valid bit from 1 to 0. `cmd_ready_o` is low in that cycle. An invalidate that clears nothing raises no flush.
- R10: Reset clears every entry to zero, leaves the block ready, and drives no response and no flush. Each accepted command gives `rsp_valid_o` in the next cycle. Opcodes 5 to 7 respond with an error and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_1t_i | input | 1 | High when 1 TB segments may be stored |
| lk_addr_i | input | 64 | Effective address to translate |
| lk_hit_o | output | 1 | Some slot matches the address |
| lk_slot_o | output | log2(NUM_SLOTS) | Winning slot number |
| lk_vsid_o | output | 64 | VSID word of the winning slot |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 3 | Opcode (0 write, 1 read ESID, 2 read VSID, 3 invalidate all, 4 invalidate by address) |
| cmd_rb_i | input | 64 | ESID word plus slot field, read slot, or address to invalidate |
| cmd_rs_i | input | 64 | VSID word for a write |
| rsp_valid_o | output | 1 | Response for the command accepted in the previous cycle |
| rsp_err_o | output | 1 | Command was rejected or invalid |
| rsp_data_o | output | 64 | Read data, zero otherwise |
| tlb_flush_o | output | 1 | One-cycle request to flush the downstream translation cache |

## Verification
The assertions assume that the command fields stay stable while `cmd_valid_i` is high and the block is not ready. They also assume that `cap_1t_i` changes only between commands and that NUM_SLOTS is a power of two, so the slot-field rejection mask and the slot index agree. The bench changes every input only on falling clock edges. It holds each command until it is accepted, and it never changes the capability input while a command is in flight. The bench runs with eight slots, so the sweeps can cover every 12-bit slot field, every size code under both capability settings, and every read slot up to twice the slot count.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int WORD_W      = 64;
    localparam int SEG_LSB     = 28;   // lowest segment-number bit of an ESID word
    localparam int TERA_LSB    = 40;   // lowest bit compared for a 1 TB segment
    localparam int VALID_BIT   = 27;
    localparam int SLOT_FLD_W  = 12;
    localparam int SEG_W       = WORD_W - SEG_LSB;

    localparam logic [WORD_W-1:0] ESID_KEEP = 64'hFFFF_FFFF_F800_0000;

    localparam logic [1:0] SIZE_256M = 2'b00;
    localparam logic [1:0] SIZE_1T   = 2'b01;

    localparam logic [2:0] OP_WRITE    = 3'd0;
    localparam logic [2:0] OP_RD_ESID  = 3'd1;
    localparam logic [2:0] OP_RD_VSID  = 3'd2;
    localparam logic [2:0] OP_INV_ALL  = 3'd3;
    localparam logic [2:0] OP_INV_ADDR = 3'd4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } slb_state_e;

endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] esid_tab,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] vsid_tab,
    input  logic [SEG_W-1:0]                 seg_i,
    output logic                             hit_o,
    output logic [SLOT_W-1:0]                slot_o,
    output word_t                            vsid_o
);

    localparam int TERA_W = WORD_W - TERA_LSB;
    localparam int GAP_W  = TERA_LSB - SEG_LSB;

    word_t tag_small;
    word_t tag_large;
    logic [NUM_SLOTS-1:0] match;

    assign tag_small = {seg_i, 1'b1, {VALID_BIT{1'b0}}};
    assign tag_large = {seg_i[SEG_W-1 -: TERA_W], {GAP_W{1'b0}}, 1'b1, {VALID_BIT{1'b0}}};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        logic size_small;
        logic size_large;
        assign size_small = (vsid_tab[g][WORD_W-1 -: 2] == SIZE_256M);
        assign size_large = (vsid_tab[g][WORD_W-1 -: 2] == SIZE_1T);
        assign match[g] = ((esid_tab[g] == tag_small) && size_small)
                       || ((esid_tab[g] == tag_large) && size_large);
    end

    always_comb begin
        slot_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                slot_o = SLOT_W'(i);
            end
        end
    end

    assign hit_o  = |match;
    assign vsid_o = hit_o ? vsid_tab[slot_o] : '0;

endmodule

// File: rtl/slb_wcheck.sv
module slb_wcheck
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_FLD_W-1:0] slot_fld_i,
    input  logic [1:0]            size_i,
    input  logic                  cap_1t_i,
    output logic                  ok_o,
    output logic [SLOT_W-1:0]     slot_o
);

    localparam logic [SLOT_FLD_W-1:0] HIGH_MASK = SLOT_FLD_W'((1 << SLOT_FLD_W) - NUM_SLOTS);

    logic bad_slot;
    logic bad_size;
    logic no_cap;

    assign bad_slot = |(slot_fld_i & HIGH_MASK);
    assign bad_size = size_i[1];
    assign no_cap   = (size_i == SIZE_1T) && !cap_1t_i;
    assign ok_o     = !(bad_slot || bad_size || no_cap);
    assign slot_o   = slot_fld_i[SLOT_W-1:0];

endmodule

// File: rtl/slb_top.sv
module slb_top
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_1t_i,
    input  logic [63:0]       lk_addr_i,
    output logic              lk_hit_o,
    output logic [SLOT_W-1:0] lk_slot_o,
    output logic [63:0]       lk_vsid_o,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [2:0]        cmd_op_i,
    input  logic [63:0]       cmd_rb_i,
    input  logic [63:0]       cmd_rs_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [63:0]       rsp_data_o,
    output logic              tlb_flush_o
);

    logic [NUM_SLOTS-1:0][WORD_W-1:0] esid_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] vsid_q;

    slb_state_e state_q;
    slb_state_e state_d;

    logic              accept;
    logic              wr_ok;
    logic [SLOT_W-1:0] wr_slot;
    logic              ia_hit;
    logic [SLOT_W-1:0] ia_slot;
    word_t             ia_vsid;
    logic              any_upper_valid;
    logic              rd_in_range;
    logic [SLOT_W-1:0] rd_slot;
    logic              drop;
    logic              rsp_err_d;
    word_t             rsp_data_d;
    logic              unused_bits;

    // Lookup port
    slb_match #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_lookup (
        .esid_tab (esid_q),
        .vsid_tab (vsid_q),
        .seg_i    (lk_addr_i[WORD_W-1:SEG_LSB]),
        .hit_o    (lk_hit_o),
        .slot_o   (lk_slot_o),
        .vsid_o   (lk_vsid_o)
    );

    // Second comparator array serving invalidate-by-address
    slb_match #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_inv_lookup (
        .esid_tab (esid_q),
        .vsid_tab (vsid_q),
        .seg_i    (cmd_rb_i[WORD_W-1:SEG_LSB]),
        .hit_o    (ia_hit),
        .slot_o   (ia_slot),
        .vsid_o   (ia_vsid)
    );

    slb_wcheck #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_wcheck (
        .slot_fld_i (cmd_rb_i[SLOT_FLD_W-1:0]),
        .size_i     (cmd_rs_i[WORD_W-1 -: 2]),
        .cap_1t_i   (cap_1t_i),
        .ok_o       (wr_ok),
        .slot_o     (wr_slot)
    );

    assign unused_bits = ^{lk_addr_i[SEG_LSB-1:0], cmd_rb_i[VALID_BIT-1:SLOT_FLD_W], ia_vsid};

    assign accept      = cmd_valid_i && cmd_ready_o;
    assign rd_slot     = cmd_rb_i[SLOT_W-1:0];
    assign rd_in_range = ({1'b0, cmd_rb_i[SLOT_FLD_W-1:0]} < (SLOT_FLD_W+1)'(NUM_SLOTS));

    always_comb begin
        any_upper_valid = 1'b0;
        for (int i = 1; i < NUM_SLOTS; i++) begin
            any_upper_valid = any_upper_valid | esid_q[i][VALID_BIT];
        end
    end

    assign drop = accept && (((cmd_op_i == OP_INV_ALL) && any_upper_valid)
                          || ((cmd_op_i == OP_INV_ADDR) && ia_hit));

    // Table storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esid_q <= '0;
            vsid_q <= '0;
        end else if (accept) begin
            case (cmd_op_i)
                OP_WRITE: begin
                    if (wr_ok) begin
                        esid_q[wr_slot] <= cmd_rb_i & ESID_KEEP;
                        vsid_q[wr_slot] <= cmd_rs_i;
                    end
                end
                OP_INV_ALL: begin
                    for (int i = 1; i < NUM_SLOTS; i++) begin
                        esid_q[i][VALID_BIT] <= 1'b0;
                    end
                end
                OP_INV_ADDR: begin
                    if (ia_hit) begin
                        esid_q[ia_slot][VALID_BIT] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Response decode
    always_comb begin
        rsp_err_d  = 1'b0;
        rsp_data_d = '0;
        case (cmd_op_i)
            OP_WRITE:    rsp_err_d = !wr_ok;
            OP_RD_ESID: begin
                rsp_err_d  = !rd_in_range;
                rsp_data_d = rd_in_range ? esid_q[rd_slot] : '0;
            end
            OP_RD_VSID: begin
                rsp_err_d  = !rd_in_range;
                rsp_data_d = rd_in_range ? vsid_q[rd_slot] : '0;
            end
            OP_INV_ALL:  rsp_err_d = 1'b0;
            OP_INV_ADDR: rsp_err_d = 1'b0;
            default:     rsp_err_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= accept;
            rsp_err_o   <= accept ? rsp_err_d : 1'b0;
            rsp_data_o  <= accept ? rsp_data_d : '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: drop and resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (drop) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        cmd_ready_o = 1'b0;
        tlb_flush_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_ready_o = 1'b1;
            ST_FLUSH: tlb_flush_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/slb_chk.sv
module slb_chk
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cap_1t_i,
    input logic                  cmd_valid_i,
    input logic                  cmd_ready_o,
    input logic [2:0]            cmd_op_i,
    input logic [SLOT_FLD_W-1:0] slot_fld,
    input logic [1:0]            rs_size,
    input logic                  rsp_valid_o,
    input logic                  rsp_err_o,
    input logic                  tlb_flush_o,
    input logic [WORD_W-1:0]     slot0_esid
);

    localparam logic [SLOT_FLD_W-1:0] HIGH_MASK = SLOT_FLD_W'((1 << SLOT_FLD_W) - NUM_SLOTS);

    logic acc;
    assign acc = cmd_valid_i && cmd_ready_o;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid_o); // R10

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(acc)); // R10

    AST_SLOT_FIELD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op_i == OP_WRITE && |(slot_fld & HIGH_MASK)) |=> rsp_err_o); // R3

    AST_NO_1T_WITHOUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op_i == OP_WRITE && rs_size == SIZE_1T && !cap_1t_i) |=> rsp_err_o); // R4

    AST_SLOT0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op_i == OP_INV_ALL) |=> $stable(slot0_esid)); // R7

    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |=> !tlb_flush_o); // R9

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> !cmd_ready_o); // R9

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_flush_o) |-> $past(acc && (cmd_op_i == OP_INV_ALL || cmd_op_i == OP_INV_ADDR))); // R9

endmodule

bind slb_top slb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_slb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_1t_i    (cap_1t_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_op_i    (cmd_op_i),
    .slot_fld    (cmd_rb_i[11:0]),
    .rs_size     (cmd_rs_i[63:62]),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .tlb_flush_o (tlb_flush_o),
    .slot0_esid  (esid_q[0])
);

// File: tb/test_slb_top.sv
module test_slb_top;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_1t = 1'b1;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [2:0]  lk_slot;
    logic [63:0] lk_vsid;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_rb = '0;
    logic [63:0] cmd_rs = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;
    logic        tlb_flush;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] m_esid [N];
    logic [63:0] m_vsid [N];

    always #5 clk = ~clk;

    slb_top #(.NUM_SLOTS(N)) i_slb_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_1t_i    (cap_1t),
        .lk_addr_i   (lk_addr),
        .lk_hit_o    (lk_hit),
        .lk_slot_o   (lk_slot),
        .lk_vsid_o   (lk_vsid),
        .cmd_valid_i (cmd_valid),
        .cmd_ready_o (cmd_ready),
        .cmd_op_i    (cmd_op),
        .cmd_rb_i    (cmd_rb),
        .cmd_rs_i    (cmd_rs),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_data_o  (rsp_data),
        .tlb_flush_o (tlb_flush)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [63:0] rb, input logic [63:0] rs,
                          output logic err, output logic [63:0] data,
                          output logic flush, output logic rdy);
        cmd_op = op; cmd_rb = rb; cmd_rs = rs; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        err = rsp_err; data = rsp_data; flush = tlb_flush; rdy = cmd_ready;
        check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
    endtask

    function automatic logic [63:0] esid_word(input logic [35:0] seg, input logic v);
        return {seg, v, 27'b0};
    endfunction

    // Expected lookup from R1 and R2
    task automatic exp_lookup(input logic [63:0] a, output logic hit, output logic [2:0] slot,
                              output logic [63:0] vs);
        hit = 1'b0; slot = '0; vs = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if ((m_esid[i] == esid_word(a[63:28], 1'b1) && m_vsid[i][63:62] == 2'b00) ||
                (m_esid[i] == esid_word({a[63:40], 12'h000}, 1'b1) && m_vsid[i][63:62] == 2'b01)) begin
                hit = 1'b1; slot = 3'(i); vs = m_vsid[i];
            end
        end
    endtask

    task automatic probe(input string req, input logic [63:0] a);
        logic eh; logic [2:0] es; logic [63:0] ev;
        lk_addr = a;
        #1;
        exp_lookup(a, eh, es, ev);
        check({req, " hit"},  64'(lk_hit), 64'(eh));
        check({req, " slot"}, 64'(lk_slot), 64'(es));
        check({req, " vsid"}, lk_vsid, ev);
    endtask

    task automatic model_write(input logic [63:0] rb, input logic [63:0] rs, output logic e);
        e = (|(rb[11:0] & 12'hFF8)) || rs[63] || (rs[62] && !cap_1t);
        if (!e) begin
            m_esid[rb[2:0]] = rb & 64'hFFFF_FFFF_F800_0000;
            m_vsid[rb[2:0]] = rs;
        end
    endtask

    task automatic check_all_slots(input string req);
        logic e; logic [63:0] d; logic f; logic r;
        for (int s = 0; s < N; s++) begin
            do_cmd(3'd1, 64'(s), '0, e, d, f, r);
            check({req, " esid"}, d, m_esid[s]);
            do_cmd(3'd2, 64'(s), '0, e, d, f, r);
            check({req, " vsid"}, d, m_vsid[s]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic e, ee, f, r;
        logic [63:0] d, rb, rs;

        for (int i = 0; i < N; i++) begin
            m_esid[i] = '0;
            m_vsid[i] = '0;
        end

        repeat (3) @(negedge clk);
        check("R10 ready in reset", 64'(cmd_ready), 64'd1);
        check("R10 no rsp in reset", 64'(rsp_valid), 64'd0);
        check("R10 no flush in reset", 64'(tlb_flush), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_slots("R10 reset contents");
        probe("R10 reset lookup", 64'h0);

        // R3: sweep every value of the 12-bit slot field
        cap_1t = 1'b1;
        for (int s = 0; s < 4096; s++) begin
            rb = {36'(s * 7 + 1), 1'b1, 15'h1A5A, 12'(s)};
            rs = {2'b00, 62'(s * 3 + 5)};
            model_write(rb, rs, ee);
            do_cmd(3'd0, rb, rs, e, d, f, r);
            check("R3 slot field", 64'(e), 64'(ee));
        end
        check_all_slots("R5 stored words");

        // R6: reads over twice the slot range
        for (int s = 0; s < 2 * N; s++) begin
            do_cmd(3'd1, {52'hABCDE, 12'(s)}, '0, e, d, f, r);
            check("R6 esid err", 64'(e), 64'(s >= N));
            check("R6 esid data", d, (s < N) ? m_esid[s % N] : 64'h0);
            do_cmd(3'd2, 64'(s), '0, e, d, f, r);
            check("R6 vsid err", 64'(e), 64'(s >= N));
            check("R6 vsid data", d, (s < N) ? m_vsid[s % N] : 64'h0);
        end

        // R4: every size code under both capability settings
        for (int c = 0; c < 2; c++) begin
            for (int z = 0; z < 4; z++) begin
                cap_1t = c[0];
                rb = {36'(16 + z + 4 * c), 1'b1, 15'h0, 12'd3};
                rs = {z[1:0], 62'(100 + z)};
                model_write(rb, rs, ee);
                do_cmd(3'd0, rb, rs, e, d, f, r);
                check("R4 size err", 64'(e), 64'(ee));
                do_cmd(3'd2, 64'd3, '0, e, d, f, r);
                check("R4 vsid after size", d, m_vsid[3]);
            end
        end
        cap_1t = 1'b1;

        // Lookup table set-up for R1/R2
        model_write(esid_word(36'h000000001, 1'b1) | 64'd0, {2'b00, 62'h11}, ee);
        do_cmd(3'd0, esid_word(36'h000000001, 1'b1) | 64'd0, {2'b00, 62'h11}, e, d, f, r);
        model_write(esid_word({24'h000002, 12'h000}, 1'b1) | 64'd1, {2'b01, 62'h22}, ee);
        do_cmd(3'd0, esid_word({24'h000002, 12'h000}, 1'b1) | 64'd1, {2'b01, 62'h22}, e, d, f, r);
        model_write(esid_word({24'h000002, 12'h005}, 1'b1) | 64'd2, {2'b00, 62'h33}, ee);
        do_cmd(3'd0, esid_word({24'h000002, 12'h005}, 1'b1) | 64'd2, {2'b00, 62'h33}, e, d, f, r);
        model_write(esid_word(36'h000000003, 1'b1) | 64'd3, {2'b00, 62'h44}, ee);
        do_cmd(3'd0, esid_word(36'h000000003, 1'b1) | 64'd3, {2'b00, 62'h44}, e, d, f, r);
        model_write(esid_word(36'h000000003, 1'b1) | 64'd4, {2'b00, 62'h55}, ee);
        do_cmd(3'd0, esid_word(36'h000000003, 1'b1) | 64'd4, {2'b00, 62'h55}, e, d, f, r);
        model_write(esid_word({24'h000004, 12'h001}, 1'b1) | 64'd5, {2'b01, 62'h66}, ee);
        do_cmd(3'd0, esid_word({24'h000004, 12'h001}, 1'b1) | 64'd5, {2'b01, 62'h66}, e, d, f, r);
        model_write(esid_word(36'h000000006, 1'b0) | 64'd6, {2'b00, 62'h77}, ee);
        do_cmd(3'd0, esid_word(36'h000000006, 1'b0) | 64'd6, {2'b00, 62'h77}, e, d, f, r);
        model_write(esid_word({24'h000007, 12'h000}, 1'b1) | 64'd7, {2'b01, 62'h88}, ee);
        do_cmd(3'd0, esid_word({24'h000007, 12'h000}, 1'b1) | 64'd7, {2'b01, 62'h88}, e, d, f, r);
        check_all_slots("R5 lookup set-up");

        // R1 sweep over the segment bits
        for (int hi = 0; hi < 9; hi++) begin
            for (int m = 0; m < 8; m++) begin
                probe("R1 sweep", {24'(hi), (m == 4) ? 12'hFFF : 12'(m), 28'h0ABCDEF});
            end
        end

        // R2: explicit priority cases
        lk_addr = {24'h0, 12'h003, 28'h1234567};
        #1;
        check("R2 duplicate 256M", 64'(lk_slot), 64'd3);
        lk_addr = {24'h2, 12'h005, 28'h0};
        #1;
        check("R2 1T over 256M", 64'(lk_slot), 64'd1);
        check("R2 1T vsid", lk_vsid, {2'b01, 62'h22});

        // R8/R9: invalidate by address, hit then miss
        @(negedge clk);
        do_cmd(3'd4, {24'h0, 12'h003, 28'h0}, '0, e, d, f, r);
        m_esid[3][27] = 1'b0;
        check("R9 flush on inv hit", 64'(f), 64'd1);
        check("R9 ready low during flush", 64'(r), 64'd0);
        check("R8 inv err", 64'(e), 64'd0);
        probe("R8 next slot after inv", {24'h0, 12'h003, 28'h0});
        check("R8 now slot4", 64'(lk_slot), 64'd4);
        do_cmd(3'd4, {24'h0, 12'h006, 28'h0}, '0, e, d, f, r);
        check("R9 no flush on inv miss", 64'(f), 64'd0);
        check_all_slots("R8 miss changes nothing");

        // R7/R9: invalidate all, twice
        do_cmd(3'd3, '0, '0, e, d, f, r);
        for (int i = 1; i < N; i++) m_esid[i][27] = 1'b0;
        check("R9 flush on inv all", 64'(f), 64'd1);
        check_all_slots("R7 after inv all");
        probe("R7 slot0 kept", {24'h0, 12'h001, 28'h0});
        check("R7 slot0 still hits", 64'(lk_hit), 64'd1);
        do_cmd(3'd3, '0, '0, e, d, f, r);
        check("R9 no flush when only slot0 valid", 64'(f), 64'd0);

        // R10: reserved opcodes
        for (int op = 5; op < 8; op++) begin
            do_cmd(3'(op), 64'd2, 64'h1, e, d, f, r);
            check("R10 reserved op err", 64'(e), 64'd1);
            check("R10 reserved op no flush", 64'(f), 64'd0);
        end
        check_all_slots("R10 reserved op no change");

        // R10: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_esid[i] = '0;
            m_vsid[i] = '0;
        end
        @(negedge clk);
        check_all_slots("R10 reset clears");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule